// File: doc/BRIEF.md
# Hidden Address Register Update Unit

This block keeps the 16-bit internal address register of an 8-bit processor core. Software cannot read this register directly, but it can see it through flag bits. The core's decoder sends the block one decoded event per instruction. The event carries these fields:

- the prefix page code
- the opcode
- the effective memory address, or the immediate `nn`
- the accumulator, BC, and HL (or the index register) as they were before the instruction
- the new program-counter value
- a condition-met bit
- the operand tested by a register BIT instruction

On the cycle where the completion strobe is high, the block applies the per-opcode update rule for that event. Opcodes that have no rule leave the register unchanged.

The block also drives the two copy-flag values, flag bit 5 and flag bit 3, that the flag logic uses for BIT instructions. For a memory-operand BIT these values come from the high byte of the register. For a register-operand BIT they come from the tested operand.

Top module: `wz_tracker`

## Requirements
- R1: An active-high synchronous `rst` clears `wz` to 0x0000. `wz` changes only on a rising clock edge where `step` is 1. The page codes on `page` are: 0 = unprefixed, 1 = CB, 2 = DD, 3 = ED, 4 = FD, 5 = DD CB, 6 = FD CB, 7 = no rule.
- R2: On page 0, opcodes 0x0A, 0x1A and 0x3A (load A from memory) set `wz` to `addr`+1, modulo 65536.
- R3: On page 0, opcodes 0x02, 0x12 and 0x32 (store A to memory) set `wz` to {`acc`, low byte of `addr`+1}. The carry out of the low byte is dropped.
- R4: The 16-bit loads to or from (nn) set `wz` to `addr`+1. These are opcodes 0x22 and 0x2A on pages 0, 2 and 4, and opcodes 0x43, 0x4B, 0x53, 0x5B, 0x63, 0x6B, 0x73 and 0x7B on page 3.
- R5: The following opcodes set `wz` to `hl`+1, where `hl` is the value before the instruction:
  - 16-bit add: opcodes 0x09, 0x19, 0x29 and 0x39 on pages 0, 2 and 4.
  - Add and subtract with carry: opcodes 0x4A, 0x5A, 0x6A, 0x7A, 0x42, 0x52, 0x62 and 0x72 on page 3.
  - Digit rotates: opcodes 0x67 and 0x6F on page 3.
- R6: On page 3, opcodes 0x78 and 0x79 (input and output through port C) set `wz` to `bc`+1.
- R7: On page 3, opcodes 0xA1 and 0xB1 (compare-increment) add 1 to `wz`, and opcodes 0xA9 and 0xB9 (compare-decrement) subtract 1. Both wrap modulo 65536.
- R8: `wz` takes the value of `dest` for these page-0 opcodes:
  - 0x18 (relative jump) and 0xC9 (return), always.
  - 0xCD (call), always.
  - 0x20, 0x28, 0x30 and 0x38 (conditional relative jumps), only when `taken` is 1.
  
  Page-3 opcode 0x4D (interrupt return) also sets `wz` to `dest`. A page-0 restart opcode (0xC7 | n<<3) sets `wz` to n*8 and ignores `dest`.
- R9: Page-0 opcode 0x10 (decrement-and-branch) sets `wz` to `dest` whether or not the branch is taken. When the count reaches zero, `dest` is the fall-through program counter.
- R10: `xy` is {bit 5, bit 3}. For a memory BIT, `xy` is {`wz`[13], `wz`[11]}. A memory BIT is a page-1 opcode with bits 7:6 = 01 and bits 2:0 = 110, or any page-5 or page-6 opcode with bits 7:6 = 01. In every other case `xy` is {`opnd`[5], `opnd`[3]}. A BIT instruction does not change `wz`.
- R11: Every other opcode leaves `wz` unchanged. This includes a conditional relative jump with `taken` = 0, an absolute jump (0xC3), the page-3 opcode 0x45, every page-1 opcode, and page 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Instruction-complete strobe |
| page | input | 3 | Prefix page code |
| opc | input | 8 | Opcode within the page |
| addr | input | 16 | Effective memory address or immediate nn |
| acc | input | 8 | Accumulator value |
| bc | input | 16 | BC pair value |
| hl | input | 16 | HL or index register value before the instruction |
| dest | input | 16 | New program-counter value |
| taken | input | 1 | Condition met for a conditional relative jump |
| opnd | input | 8 | Operand of a register BIT |
| wz | output | 16 | Hidden address register |
| xy | output | 2 | Copy-flag values {bit 5, bit 3} |

## Verification
The bench checks the wrap-around corners:
- `addr` = 0xFFFF on a load gives 0x0000.
- A store with a low byte of 0xFF must keep the accumulator in the high byte. A design that lets the carry propagate would show `acc`+1 there.
- A compare-decrement from 0x0000 must give 0xFFFF.

It runs every restart vector with a misleading `dest`. This catches a design that follows `dest` for restarts instead of decoding the vector from the opcode.

It checks that a conditional jump with `taken` = 0 holds `wz`, while a decrement-and-branch that falls through still loads `dest`. Swapping these two rules would be visible in either case.

It selects both memory and register BIT forms. A design that mixes up the source of `xy`, or that writes `wz` on a BIT, shows the wrong flag pair.

// File: rtl/wz_tracker.sv
module wz_tracker (
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  input  logic [2:0]  page,
  input  logic [7:0]  opc,
  input  logic [15:0] addr,
  input  logic [7:0]  acc,
  input  logic [15:0] bc,
  input  logic [15:0] hl,
  input  logic [15:0] dest,
  input  logic        taken,
  input  logic [7:0]  opnd,
  output logic [15:0] wz,
  output logic [1:0]  xy
);
  localparam logic [2:0] PG_BASE = 3'd0, PG_CB = 3'd1, PG_DD = 3'd2, PG_ED = 3'd3,
                         PG_FD = 3'd4, PG_DDCB = 3'd5, PG_FDCB = 3'd6;

  logic [15:0] nxt;
  logic        mem_bit;

  always_comb begin
    nxt = wz;
    case (page)
      PG_BASE:
        case (opc)
          8'h0A, 8'h1A, 8'h3A, 8'h22, 8'h2A: nxt = addr + 16'd1;
          8'h02, 8'h12, 8'h32:               nxt = {acc, addr[7:0] + 8'd1};
          8'h09, 8'h19, 8'h29, 8'h39:        nxt = hl + 16'd1;
          8'h10, 8'h18, 8'hC9, 8'hCD:        nxt = dest;
          8'h20, 8'h28, 8'h30, 8'h38:        if (taken) nxt = dest;
          default:
            if (opc[7:6] == 2'b11 && opc[2:0] == 3'b111) nxt = {10'd0, opc[5:3], 3'd0};
        endcase
      PG_DD, PG_FD:
        case (opc)
          8'h22, 8'h2A:               nxt = addr + 16'd1;
          8'h09, 8'h19, 8'h29, 8'h39: nxt = hl + 16'd1;
          default: ;
        endcase
      PG_ED:
        case (opc)
          8'h42, 8'h52, 8'h62, 8'h72,
          8'h4A, 8'h5A, 8'h6A, 8'h7A,
          8'h67, 8'h6F:               nxt = hl + 16'd1;
          8'h43, 8'h53, 8'h63, 8'h73,
          8'h4B, 8'h5B, 8'h6B, 8'h7B: nxt = addr + 16'd1;
          8'h78, 8'h79:               nxt = bc + 16'd1;
          8'hA1, 8'hB1:               nxt = wz + 16'd1;
          8'hA9, 8'hB9:               nxt = wz - 16'd1;
          8'h4D:                      nxt = dest;
          default: ;
        endcase
      default: ;
    endcase
  end

  always_ff @(posedge clk)
    if (rst)       wz <= 16'h0000;
    else if (step) wz <= nxt;

  assign mem_bit = (opc[7:6] == 2'b01) &&
                   ((page == PG_CB && opc[2:0] == 3'b110) || page == PG_DDCB || page == PG_FDCB);
  assign xy = mem_bit ? {wz[13], wz[11]} : {opnd[5], opnd[3]};
endmodule

// File: rtl/wz_tracker_chk.sv
module wz_tracker_chk (
  input logic        clk,
  input logic        rst,
  input logic        step,
  input logic [2:0]  page,
  input logic [7:0]  opc,
  input logic [7:0]  acc,
  input logic [15:0] bc,
  input logic [15:0] dest,
  input logic [15:0] wz
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> wz == 16'h0000);
  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst) !step |=> $stable(wz));
  // R3
  store_high_chk: assert property (@(posedge clk) disable iff (rst)
    step && page == 3'd0 && (opc == 8'h02 || opc == 8'h12 || opc == 8'h32) |=> wz[15:8] == $past(acc));
  // R6
  port_c_chk: assert property (@(posedge clk) disable iff (rst)
    step && page == 3'd3 && (opc == 8'h78 || opc == 8'h79) |=> wz == $past(bc) + 16'd1);
  // R7
  cmp_inc_chk: assert property (@(posedge clk) disable iff (rst)
    step && page == 3'd3 && (opc == 8'hA1 || opc == 8'hB1) |=> wz == $past(wz) + 16'd1);
  // R9
  djnz_dest_chk: assert property (@(posedge clk) disable iff (rst)
    step && page == 3'd0 && opc == 8'h10 |=> wz == $past(dest));
  // R11
  cb_page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    step && page == 3'd1 |=> $stable(wz));
endmodule

bind wz_tracker wz_tracker_chk i_chk (
  .clk(clk), .rst(rst), .step(step), .page(page), .opc(opc),
  .acc(acc), .bc(bc), .dest(dest), .wz(wz)
);

// File: tb/test_wz_tracker.sv
module test_wz_tracker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, step = 1'b0, taken = 1'b0;
  logic [2:0] page = '0;
  logic [7:0] opc = '0, acc = '0, opnd = '0;
  logic [15:0] addr = '0, bc = '0, hl = '0, dest = '0;
  logic [15:0] wz;
  logic [1:0] xy;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wz_tracker i_wz_tracker (.clk(clk), .rst(rst), .step(step), .page(page), .opc(opc),
    .addr(addr), .acc(acc), .bc(bc), .hl(hl), .dest(dest), .taken(taken), .opnd(opnd),
    .wz(wz), .xy(xy));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic ev(input logic [2:0] pg, input logic [7:0] op, input logic [15:0] ad,
                    input logic [7:0] a, input logic [15:0] b, input logic [15:0] h,
                    input logic [15:0] d, input logic tk, input logic [7:0] od);
    page = pg; opc = op; addr = ad; acc = a; bc = b; hl = h; dest = d; taken = tk; opnd = od;
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
  endtask

  task automatic preset(input logic [15:0] v);
    ev(3'd0, 8'h3A, v - 16'd1, 8'h00, 16'h0, 16'h0, 16'h0, 1'b0, 8'h00);
  endtask

  function automatic logic [15:0] rnd();
    return 16'($urandom);
  endfunction

  task automatic t_reset();
    chk("R1 reset value", wz, 16'h0000);
    preset(16'h1234);
    page = 3'd0; opc = 8'h3A; addr = 16'h7777; step = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 no strobe hold", wz, 16'h1234);
  endtask

  task automatic t_load_a();
    logic [7:0] ops[3] = '{8'h0A, 8'h1A, 8'h3A};
    foreach (ops[i]) for (int k = 0; k < 4; k++) begin
      logic [15:0] a = rnd();
      ev(3'd0, ops[i], a, 8'h00, rnd(), rnd(), rnd(), 1'b1, 8'h00);
      chk("R2 load A", wz, a + 16'd1);
    end
    ev(3'd0, 8'h3A, 16'hFFFF, 8'h00, 16'h0, 16'h0, 16'h0, 1'b0, 8'h00);
    chk("R2 wrap", wz, 16'h0000);
  endtask

  task automatic t_store_a();
    logic [7:0] ops[3] = '{8'h02, 8'h12, 8'h32};
    foreach (ops[i]) begin
      logic [15:0] a = rnd();
      logic [7:0] v = 8'($urandom);
      ev(3'd0, ops[i], a, v, rnd(), rnd(), rnd(), 1'b1, 8'h00);
      chk("R3 store A", wz, {v, a[7:0] + 8'd1});
    end
    ev(3'd0, 8'h32, 16'h12FF, 8'h5C, 16'h0, 16'h0, 16'h0, 1'b0, 8'h00);
    chk("R3 low carry dropped", wz, 16'h5C00);
  endtask

  task automatic t_ld16();
    logic [7:0] edops[8] = '{8'h43, 8'h4B, 8'h53, 8'h5B, 8'h63, 8'h6B, 8'h73, 8'h7B};
    logic [2:0] pgs[3] = '{3'd0, 3'd2, 3'd4};
    foreach (pgs[i]) begin
      logic [15:0] a = rnd();
      ev(pgs[i], 8'h22, a, 8'h00, rnd(), rnd(), rnd(), 1'b0, 8'h00);
      chk("R4 store 16", wz, a + 16'd1);
      a = rnd();
      ev(pgs[i], 8'h2A, a, 8'h00, rnd(), rnd(), rnd(), 1'b0, 8'h00);
      chk("R4 load 16", wz, a + 16'd1);
    end
    foreach (edops[i]) begin
      logic [15:0] a = rnd();
      ev(3'd3, edops[i], a, 8'h00, rnd(), rnd(), rnd(), 1'b0, 8'h00);
      chk("R4 ext page", wz, a + 16'd1);
    end
  endtask

  task automatic t_hl();
    logic [7:0] edops[10] = '{8'h42, 8'h52, 8'h62, 8'h72, 8'h4A, 8'h5A, 8'h6A, 8'h7A, 8'h67, 8'h6F};
    logic [7:0] bops[4] = '{8'h09, 8'h19, 8'h29, 8'h39};
    foreach (bops[i]) begin
      logic [15:0] h = rnd();
      ev(3'd0, bops[i], rnd(), 8'h00, rnd(), h, rnd(), 1'b0, 8'h00);
      chk("R5 add 16", wz, h + 16'd1);
      h = rnd();
      ev(3'd4, bops[i], rnd(), 8'h00, rnd(), h, rnd(), 1'b0, 8'h00);
      chk("R5 indexed add", wz, h + 16'd1);
    end
    foreach (edops[i]) begin
      logic [15:0] h = rnd();
      ev(3'd3, edops[i], rnd(), 8'h00, rnd(), h, rnd(), 1'b0, 8'h00);
      chk("R5 adc/sbc/rotate", wz, h + 16'd1);
    end
  endtask

  task automatic t_port();
    logic [15:0] b = rnd();
    ev(3'd3, 8'h78, rnd(), 8'h00, b, rnd(), rnd(), 1'b0, 8'h00);
    chk("R6 input", wz, b + 16'd1);
    ev(3'd3, 8'h79, rnd(), 8'h00, 16'hFFFF, rnd(), rnd(), 1'b0, 8'h00);
    chk("R6 output wrap", wz, 16'h0000);
  endtask

  task automatic t_cmp();
    preset(16'h4000);
    ev(3'd3, 8'hA1, rnd(), 8'h00, rnd(), rnd(), rnd(), 1'b0, 8'h00);
    ev(3'd3, 8'hB1, rnd(), 8'h00, rnd(), rnd(), rnd(), 1'b0, 8'h00);
    chk("R7 increment", wz, 16'h4002);
    ev(3'd3, 8'hA9, rnd(), 8'h00, rnd(), rnd(), rnd(), 1'b0, 8'h00);
    chk("R7 decrement", wz, 16'h4001);
    preset(16'h0000);
    ev(3'd3, 8'hB9, rnd(), 8'h00, rnd(), rnd(), rnd(), 1'b0, 8'h00);
    chk("R7 decrement wrap", wz, 16'hFFFF);
  endtask

  task automatic t_jump();
    logic [7:0] jcc[4] = '{8'h20, 8'h28, 8'h30, 8'h38};
    logic [15:0] d;
    d = rnd(); ev(3'd0, 8'h18, rnd(), 8'h00, rnd(), rnd(), d, 1'b0, 8'h00);
    chk("R8 relative jump", wz, d);
    d = rnd(); ev(3'd0, 8'hC9, rnd(), 8'h00, rnd(), rnd(), d, 1'b0, 8'h00);
    chk("R8 return", wz, d);
    d = rnd(); ev(3'd0, 8'hCD, rnd(), 8'h00, rnd(), rnd(), d, 1'b0, 8'h00);
    chk("R8 call", wz, d);
    d = rnd(); ev(3'd3, 8'h4D, rnd(), 8'h00, rnd(), rnd(), d, 1'b0, 8'h00);
    chk("R8 interrupt return", wz, d);
    foreach (jcc[i]) begin
      d = rnd(); ev(3'd0, jcc[i], rnd(), 8'h00, rnd(), rnd(), d, 1'b1, 8'h00);
      chk("R8 cond jump taken", wz, d);
    end
    for (int n = 0; n < 8; n++) begin
      ev(3'd0, 8'hC7 | 8'(n << 3), rnd(), 8'h00, rnd(), rnd(), 16'hBEEF, 1'b1, 8'h00);
      chk("R8 restart vector", wz, 16'(n * 8));
    end
  endtask

  task automatic t_djnz();
    logic [15:0] d = rnd();
    ev(3'd0, 8'h10, rnd(), 8'h00, rnd(), rnd(), d, 1'b1, 8'h00);
    chk("R9 branch taken", wz, d);
    d = rnd();
    ev(3'd0, 8'h10, rnd(), 8'h00, rnd(), rnd(), d, 1'b0, 8'h00);
    chk("R9 fall through", wz, d);
  endtask

  task automatic t_bit();
    preset(16'h2800);
    page = 3'd1; opc = 8'h46; opnd = 8'h00; #1;
    chk("R10 memory BIT xy", 16'(xy), 16'h3);
    page = 3'd5; opc = 8'h7E; #1;
    chk("R10 indexed BIT xy", 16'(xy), 16'h3);
    page = 3'd1; opc = 8'h47; opnd = 8'h20; #1;
    chk("R10 register BIT xy", 16'(xy), 16'h2);
    ev(3'd1, 8'h46, rnd(), 8'h00, rnd(), rnd(), rnd(), 1'b1, 8'h08);
    chk("R10 BIT keeps wz", wz, 16'h2800);
    preset(16'h0000);
    page = 3'd6; opc = 8'h46; opnd = 8'hFF; #1;
    chk("R10 memory BIT zero", 16'(xy), 16'h0);
  endtask

  task automatic t_other();
    logic [2:0] pgs[8] = '{3'd0, 3'd0, 3'd0, 3'd0, 3'd3, 3'd3, 3'd1, 3'd7};
    logic [7:0] ops[8] = '{8'h00, 8'hC3, 8'h3E, 8'h20, 8'h44, 8'h45, 8'hC6, 8'h3A};
    foreach (ops[i]) begin
      logic [15:0] v = rnd();
      preset(v);
      ev(pgs[i], ops[i], rnd(), 8'h55, rnd(), rnd(), rnd(), 1'b0, 8'hFF);
      chk("R11 unchanged", wz, v);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_a();
    t_store_a();
    t_ld16();
    t_hl();
    t_port();
    t_cmp();
    t_jump();
    t_djnz();
    t_bit();
    t_other();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule